// File: doc/BRIEF.md
# Synchronous Buck Phase Gate Sequencer

This block drives the two gate enables of one synchronous step-down power stage. It divides a fast system clock into a fixed switching period. Each period starts with a high-side interval. That interval ends on the first of three events: the PWM comparator result, the high-side overcurrent comparator, or a maximum-duty clamp. The low side then conducts until the period ends. Break-before-make spacing is enforced between the two enables, so neither side is switched on until the other has been off for a set number of ticks.

At start-up the output may already be charged. Both switches stay off until soft-start reports that it has passed feedback, or until a forced-start comparator fires. For the first periods after switching begins, a select output asks the analog side for a reduced reverse-current threshold on the low side. If the low-side sink comparator trips, the low side is released early. The high side then recirculates current for the rest of the period under its own reduced-limit comparator. Single-tick status pulses report a new period, a clamp-ended on-time, an overcurrent-ended on-time and a sink trip.

Top module: `buck_gate_seq`

## Requirements
- R1: While switching, `cyc_start` pulses for exactly one tick every PERIOD (100) ticks. That tick is position 0 of the period.
- R2: `pwm_trip` or `hs_limit` sampled high at period position p, during the high-side interval, drives `hs_gate` low from position p+2. When `hs_limit` was the cause, `ocp_hit` pulses at position p+1. `hs_limit` wins over the clamp when both end the interval at the same moment.
- R3: With no trip, the high-side interval ends at the clamp. `clamp_hit` pulses at position DUTY_MAX (94) and `hs_gate` is low from position DUTY_MAX+1 (95).
- R4: After the high side falls at position f, `ls_gate` rises at position f+DEAD and stays high through position 0 of the next period.
- R5: `hs_gate` and `ls_gate` are never high in the same tick. A gate rises only after the other has been low for DEAD (2) ticks. When the low side was on at the end of a period, `hs_gate` rises at position 1+DEAD (3). When both gates were already low, it rises at position 1.
- R6: After reset or enable, both gates stay low and `cyc_start` stays quiet while `ss_above_fb` and `force_start` are both low. Once either one is high, switching begins at the next period boundary, within PERIOD ticks.
- R7: `force_start` alone, with `ss_above_fb` low, starts switching.
- R8: `sink_lim_reduced` is high from reset or enable until SOFT_PERIODS (32) switching periods have completed. It falls in the tick of the 33rd `cyc_start`.
- R9: `ls_sink_trip` sampled high at position p, during the low-side interval, pulses `sink_hit` at p+1. It drives `ls_gate` low at p+2 and raises `hs_gate` at p+2+DEAD. The high side then stays on with no gap into the next period.
- R10: During that recirculation, `hs_recirc_trip` sampled high at position p drives `hs_gate` low at p+2. Both gates then stay low for the rest of the period.
- R11: A low `rst_n` or a low `enable` forces both gates, `cyc_start` and the status pulses low in the next tick. It restores `sink_lim_reduced` high and restarts the R6 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one tick |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Regulator enable; low holds everything off |
| pwm_trip | input | 1 | PWM comparator: current ramp crossed the error voltage |
| hs_limit | input | 1 | High-side overcurrent comparator |
| ls_sink_trip | input | 1 | Low-side reverse-current comparator |
| hs_recirc_trip | input | 1 | High-side reduced-limit comparator used during recirculation |
| ss_above_fb | input | 1 | Soft-start level has crossed feedback |
| force_start | input | 1 | Soft-start has reached the forced-start threshold |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |
| sink_lim_reduced | output | 1 | Selects the reduced low-side reverse threshold |
| cyc_start | output | 1 | Pulse at position 0 of each switching period |
| clamp_hit | output | 1 | Pulse: high-side interval ended by the duty clamp |
| ocp_hit | output | 1 | Pulse: high-side interval ended by overcurrent |
| sink_hit | output | 1 | Pulse: low-side sink trip handed the period to the high side |

## Verification
The hardest state to reach is the recirculation path. The sink comparator only acts while the low side owns the period, and the reduced-limit comparator only acts after that hand-over. The stimulus first lines up with `cyc_start`. It then ends the high side early with a PWM trip at a known position, fires the sink trip inside the low-side interval, and fires the reduced-limit trip later in the same period. The switch of the reverse-threshold select also needs 32 full periods of running, so the bench keeps a count of `cyc_start` pulses from the first one.

// File: rtl/buck_seq_pkg.sv
// Shared types for the buck phase gate sequencer.
// Assumes: one phase, one clock domain.
package buck_seq_pkg;

    // Which switch the sequencer wants on within the current period.
    typedef enum logic [1:0] {
        PH_OFF    = 2'd0,  // both off (hold, or after recirculation limit)
        PH_HIGH   = 2'd1,  // normal high-side interval
        PH_LOW    = 2'd2,  // low-side interval
        PH_RECIRC = 2'd3   // high side after a low-side sink trip
    } phase_e;

endpackage

// File: rtl/bsq_period_timer.sv
// Switching-period counter.
// Counts 0..PERIOD-1 on every tick while enabled and wraps.
// Assumes: PERIOD >= 4. Reset or a low enable parks it at 0.
module bsq_period_timer #(
    parameter int PERIOD = 100,
    localparam int CW    = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    output logic [CW-1:0] cnt,
    output logic          period_last
);

    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    assign period_last = (cnt == LAST);

    // Advance the period position, wrapping at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt <= '0;
        end else if (period_last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/bsq_startup_ctrl.sv
// Start-up hold and soft-start window.
// Keeps switching off until soft-start passes feedback or the forced-start
// comparator fires. Switching then begins at a period boundary. It also
// counts completed periods to choose the reverse-current threshold.
// Assumes: the start inputs are already synchronous to clk.
module bsq_startup_ctrl #(
    parameter int SOFT_PERIODS = 32,
    localparam int SW          = $clog2(SOFT_PERIODS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ss_above_fb,
    input  logic force_start,
    input  logic period_last,
    output logic running,
    output logic run_next,
    output logic sink_lim_reduced
);

    localparam logic [SW-1:0] SOFT_DONE = SW'(SOFT_PERIODS);

    logic [SW-1:0] soft_cnt;
    logic          start_req;

    assign start_req        = ss_above_fb | force_start;
    assign run_next         = enable & (running | (start_req & period_last));
    assign sink_lim_reduced = (soft_cnt != SOFT_DONE);

    // Latch the switching state; it only begins on a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            running <= 1'b0;
        end else begin
            running <= run_next;
        end
    end

    // Count whole periods while switching, saturating at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            soft_cnt <= '0;
        end else if (running && period_last && sink_lim_reduced) begin
            soft_cnt <= soft_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/bsq_phase_ctrl.sv
// Per-period phase decision.
// Picks which switch should conduct from the period position and the
// comparator results. It also makes the single-tick status pulses.
// Assumes: comparator inputs are synchronous; DUTY_MAX < PERIOD.
module bsq_phase_ctrl
    import buck_seq_pkg::*;
#(
    parameter int PERIOD   = 100,
    parameter int DUTY_MAX = 94,
    localparam int CW      = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic          period_last,
    input  logic          run_next,
    input  logic          pwm_trip,
    input  logic          hs_limit,
    input  logic          ls_sink_trip,
    input  logic          hs_recirc_trip,
    output phase_e        phase,
    output logic          clamp_hit,
    output logic          ocp_hit,
    output logic          sink_hit
);

    localparam logic [CW-1:0] CLAMP_AT = CW'(DUTY_MAX - 1);

    phase_e phase_nxt;
    logic   clamp_nxt;
    logic   ocp_nxt;
    logic   sink_nxt;

    // Next phase: the period boundary restarts the high side; otherwise the
    // current phase ends on its own terminating comparator.
    always_comb begin
        phase_nxt = phase;
        clamp_nxt = 1'b0;
        ocp_nxt   = 1'b0;
        sink_nxt  = 1'b0;
        if (!run_next) begin
            phase_nxt = PH_OFF;
        end else if (period_last) begin
            phase_nxt = PH_HIGH;
        end else begin
            unique case (phase)
                PH_HIGH: begin
                    if (hs_limit) begin
                        phase_nxt = PH_LOW;
                        ocp_nxt   = 1'b1;
                    end else if (pwm_trip) begin
                        phase_nxt = PH_LOW;
                    end else if (cnt == CLAMP_AT) begin
                        phase_nxt = PH_LOW;
                        clamp_nxt = 1'b1;
                    end
                end
                PH_LOW: begin
                    if (ls_sink_trip) begin
                        phase_nxt = PH_RECIRC;
                        sink_nxt  = 1'b1;
                    end
                end
                PH_RECIRC: begin
                    if (hs_recirc_trip) begin
                        phase_nxt = PH_OFF;
                    end
                end
                default: phase_nxt = phase;
            endcase
        end
    end

    // Register the phase and the status pulses together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_OFF;
            clamp_hit <= 1'b0;
            ocp_hit   <= 1'b0;
            sink_hit  <= 1'b0;
        end else begin
            phase     <= phase_nxt;
            clamp_hit <= clamp_nxt;
            ocp_hit   <= ocp_nxt;
            sink_hit  <= sink_nxt;
        end
    end

endmodule

// File: rtl/bsq_dead_time.sv
// Break-before-make gate stage.
// Turns a side off one tick after its request drops. It turns a side on only
// when the other side has been off for DEAD ticks.
// Assumes: DEAD >= 1; hs_req and ls_req are never both high.
module bsq_dead_time #(
    parameter int DEAD = 2,
    localparam int GW  = $clog2(DEAD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic hs_req,
    input  logic ls_req,
    output logic hs_gate,
    output logic ls_gate
);

    localparam logic [GW-1:0] GAP_FULL = GW'(DEAD);
    localparam logic [GW-1:0] GAP_OK   = GW'(DEAD - 1);

    logic [GW-1:0] gap;
    logic          gap_ok;

    assign gap_ok = (gap >= GAP_OK);

    // Count consecutive ticks with both gates off, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            gap <= '0;
        end else if (hs_gate || ls_gate) begin
            gap <= '0;
        end else if (gap != GAP_FULL) begin
            gap <= gap + 1'b1;
        end
    end

    // Drive the gates: stay on while requested, start only after the gap.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            hs_gate <= 1'b0;
            ls_gate <= 1'b0;
        end else begin
            hs_gate <= hs_req & (hs_gate | (!ls_gate & gap_ok));
            ls_gate <= ls_req & (ls_gate | (!hs_gate & gap_ok));
        end
    end

endmodule

// File: rtl/buck_gate_seq.sv
// Top of the buck phase gate sequencer.
// Connects the period timer, start-up hold, phase decision and dead-time
// stage. All comparator inputs are assumed synchronous to clk.
module buck_gate_seq
    import buck_seq_pkg::*;
#(
    parameter int PERIOD       = 100,
    parameter int DUTY_MAX     = 94,
    parameter int DEAD         = 2,
    parameter int SOFT_PERIODS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pwm_trip,
    input  logic hs_limit,
    input  logic ls_sink_trip,
    input  logic hs_recirc_trip,
    input  logic ss_above_fb,
    input  logic force_start,
    output logic hs_gate,
    output logic ls_gate,
    output logic sink_lim_reduced,
    output logic cyc_start,
    output logic clamp_hit,
    output logic ocp_hit,
    output logic sink_hit
);

    localparam int CW = $clog2(PERIOD);

    logic [CW-1:0] cnt;
    logic          period_last;
    logic          running;
    logic          run_next;
    phase_e        phase;
    logic          hs_req;
    logic          ls_req;

    bsq_period_timer #(.PERIOD(PERIOD)) timer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .cnt         (cnt),
        .period_last (period_last)
    );

    bsq_startup_ctrl #(.SOFT_PERIODS(SOFT_PERIODS)) start_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .enable           (enable),
        .ss_above_fb      (ss_above_fb),
        .force_start      (force_start),
        .period_last      (period_last),
        .running          (running),
        .run_next         (run_next),
        .sink_lim_reduced (sink_lim_reduced)
    );

    bsq_phase_ctrl #(.PERIOD(PERIOD), .DUTY_MAX(DUTY_MAX)) phase_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cnt            (cnt),
        .period_last    (period_last),
        .run_next       (run_next),
        .pwm_trip       (pwm_trip),
        .hs_limit       (hs_limit),
        .ls_sink_trip   (ls_sink_trip),
        .hs_recirc_trip (hs_recirc_trip),
        .phase          (phase),
        .clamp_hit      (clamp_hit),
        .ocp_hit        (ocp_hit),
        .sink_hit       (sink_hit)
    );

    assign hs_req    = (phase == PH_HIGH) || (phase == PH_RECIRC);
    assign ls_req    = (phase == PH_LOW);
    assign cyc_start = running & (cnt == '0);

    bsq_dead_time #(.DEAD(DEAD)) dead_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .hs_req  (hs_req),
        .ls_req  (ls_req),
        .hs_gate (hs_gate),
        .ls_gate (ls_gate)
    );

endmodule

// File: rtl/buck_gate_seq_chk.sv
// Assertion checker for buck_gate_seq, attached with bind.
// Watches only the top-level ports.
module buck_gate_seq_chk #(
    parameter int DEAD = 2,
    localparam int GW  = $clog2(DEAD + 1)
) (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic hs_gate,
    input logic ls_gate,
    input logic cyc_start,
    input logic clamp_hit,
    input logic ocp_hit,
    input logic sink_hit
);

    logic [GW-1:0] ls_low_run;
    logic [GW-1:0] hs_low_run;

    // Count consecutive low ticks of each gate, saturating at DEAD.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ls_low_run <= '0;
            hs_low_run <= '0;
        end else begin
            ls_low_run <= ls_gate ? '0 : ((ls_low_run == GW'(DEAD)) ? ls_low_run : ls_low_run + 1'b1);
            hs_low_run <= hs_gate ? '0 : ((hs_low_run == GW'(DEAD)) ? hs_low_run : hs_low_run + 1'b1);
        end
    end

    // R5
    gates_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));

    // R5
    hs_dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> (ls_low_run >= GW'(DEAD)));

    // R5
    ls_dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate) |-> (hs_low_run >= GW'(DEAD)));

    // R3
    clamp_ends_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_hit |=> !hs_gate);

    // R2
    ocp_ends_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ocp_hit |=> !hs_gate);

    // R9
    sink_ends_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sink_hit |=> !ls_gate);

    // R1
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> !cyc_start);

    // R11
    disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!hs_gate && !ls_gate && !cyc_start));

endmodule

bind buck_gate_seq buck_gate_seq_chk #(.DEAD(DEAD)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .hs_gate   (hs_gate),
    .ls_gate   (ls_gate),
    .cyc_start (cyc_start),
    .clamp_hit (clamp_hit),
    .ocp_hit   (ocp_hit),
    .sink_hit  (sink_hit)
);

// File: tb/buck_gate_seq_tb_top.sv
// Self-checking bench for buck_gate_seq.
module buck_gate_seq_tb_top;

    localparam int PER  = 100;
    localparam int DT   = 2;
    localparam int NVEC = 7;

    // Per-period vectors: pwm pos, ocp pos, expected hs rise, expected hs fall,
    // expected flag (0 none, 1 clamp, 2 overcurrent). -1 means no trip.
    localparam int VEC [NVEC][5] = '{
        '{-1, -1, 1, 95, 1},
        '{-1, -1, 3, 95, 1},
        '{10, -1, 3, 12, 0},
        '{-1, 50, 3, 52, 2},
        '{92, -1, 3, 94, 0},
        '{-1, 93, 3, 95, 2},
        '{40, 40, 3, 42, 2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic pwm_trip = 1'b0;
    logic hs_limit = 1'b0;
    logic ls_sink_trip = 1'b0;
    logic hs_recirc_trip = 1'b0;
    logic ss_above_fb = 1'b0;
    logic force_start = 1'b0;
    logic hs_gate, ls_gate, sink_lim_reduced, cyc_start, clamp_hit, ocp_hit, sink_hit;

    int nchk = 0;
    int nfail = 0;
    int nper = 0;
    int overlap = 0;

    logic hs_s [PER];
    logic ls_s [PER];
    logic st_s [PER];
    logic cl_s [PER];
    logic oc_s [PER];
    logic sk_s [PER];

    always #10 clk = ~clk;

    buck_gate_seq dut_i (
        .clk (clk), .rst_n (rst_n), .enable (enable),
        .pwm_trip (pwm_trip), .hs_limit (hs_limit),
        .ls_sink_trip (ls_sink_trip), .hs_recirc_trip (hs_recirc_trip),
        .ss_above_fb (ss_above_fb), .force_start (force_start),
        .hs_gate (hs_gate), .ls_gate (ls_gate),
        .sink_lim_reduced (sink_lim_reduced), .cyc_start (cyc_start),
        .clamp_hit (clamp_hit), .ocp_hit (ocp_hit), .sink_hit (sink_hit)
    );

    always @(negedge clk) begin
        if (hs_gate && ls_gate) overlap++;
    end

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Walk one period from position 0, driving trips at given positions.
    task automatic run_period(input int pwm_p, input int ocp_p, input int sink_p, input int red_p);
        for (int p = 0; p < PER; p++) begin
            hs_s[p] = hs_gate; ls_s[p] = ls_gate; st_s[p] = cyc_start;
            cl_s[p] = clamp_hit; oc_s[p] = ocp_hit; sk_s[p] = sink_hit;
            pwm_trip       = (p == pwm_p);
            hs_limit       = (p == ocp_p);
            ls_sink_trip   = (p == sink_p);
            hs_recirc_trip = (p == red_p);
            @(negedge clk);
        end
        nper++;
        check("R1 cyc_start at next period", int'(cyc_start), 1);
    endtask

    task automatic wait_start(output int seen);
        seen = 0;
        for (int i = 0; i <= PER; i++) begin
            if (cyc_start) begin
                seen = 1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic finish_run;
        check("R5 gate overlap ticks", overlap, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int act;
        int seen;
        int ones;
        repeat (4) @(negedge clk);
        // R11: reset state
        check("R11 reset hs_gate", int'(hs_gate), 0);
        check("R11 reset ls_gate", int'(ls_gate), 0);
        check("R11 reset cyc_start", int'(cyc_start), 0);
        check("R8 reset sink_lim_reduced", int'(sink_lim_reduced), 1);

        rst_n = 1'b1; enable = 1'b1;
        act = 0;
        for (int i = 0; i < 250; i++) begin
            @(negedge clk);
            if (hs_gate || ls_gate || cyc_start) act++;
        end
        check("R6 prebias hold activity", act, 0);

        ss_above_fb = 1'b1;
        wait_start(seen);
        check("R6 switching starts after soft-start cross", seen, 1);
        nper = 1;
        check("R8 reduced at first period", int'(sink_lim_reduced), 1);

        // Vector table walk: R1 R2 R3 R4 R5
        for (int v = 0; v < NVEC; v++) begin
            run_period(VEC[v][0], VEC[v][1], -1, -1);
            check("R5 hs low before rise", int'(hs_s[VEC[v][2]-1]), 0);
            check("R5 hs rise position", int'(hs_s[VEC[v][2]]), 1);
            check("R2 hs high before fall", int'(hs_s[VEC[v][3]-1]), 1);
            check("R2 hs fall position", int'(hs_s[VEC[v][3]]), 0);
            check("R4 ls low inside dead time", int'(ls_s[VEC[v][3]+DT-1]), 0);
            check("R4 ls rise position", int'(ls_s[VEC[v][3]+DT]), 1);
            check("R3 clamp_hit pulse", int'(cl_s[VEC[v][3]-1]), int'(VEC[v][4] == 1));
            check("R2 ocp_hit pulse", int'(oc_s[VEC[v][3]-1]), int'(VEC[v][4] == 2));
            ones = 0;
            for (int p = 0; p < PER; p++) ones += int'(st_s[p]);
            check("R1 one cyc_start per period", ones, 1);
            check("R1 cyc_start at position 0", int'(st_s[0]), 1);
        end

        // R8: reduced reverse threshold window of 32 periods
        while (nper < 33) begin
            if (nper == 32) check("R8 reduced at 32nd period", int'(sink_lim_reduced), 1);
            run_period(-1, -1, -1, -1);
        end
        check("R8 normal threshold at 33rd period", int'(sink_lim_reduced), 0);

        // R9: sink trip hands the period to the high side
        run_period(20, -1, 40, -1);
        check("R9 sink_hit pulse", int'(sk_s[41]), 1);
        check("R9 ls still on at trip+1", int'(ls_s[41]), 1);
        check("R9 ls off at trip+2", int'(ls_s[42]), 0);
        check("R9 hs off inside dead time", int'(hs_s[43]), 0);
        check("R9 hs on at trip+4", int'(hs_s[44]), 1);
        check("R9 hs on at period end", int'(hs_s[99]), 1);
        run_period(-1, -1, -1, -1);
        check("R9 hs continuous at next start", int'(hs_s[0]), 1);
        check("R9 hs continuous at position 1", int'(hs_s[1]), 1);
        check("R3 clamp after recirculation", int'(hs_s[95]), 0);

        // R10: reduced high-side limit during recirculation
        run_period(20, -1, 40, 60);
        check("R10 hs on before reduced trip", int'(hs_s[61]), 1);
        check("R10 hs off at trip+2", int'(hs_s[62]), 0);
        check("R10 ls stays off", int'(ls_s[80]), 0);
        check("R10 hs stays off to period end", int'(hs_s[99]), 0);
        run_period(10, -1, -1, -1);
        check("R5 hs low at position 0 after idle tail", int'(hs_s[0]), 0);
        check("R5 hs rise at position 1 after idle tail", int'(hs_s[1]), 1);

        // R11: enable low mid-period
        repeat (30) @(negedge clk);
        check("R11 hs on before disable", int'(hs_gate), 1);
        enable = 1'b0; ss_above_fb = 1'b0;
        @(negedge clk);
        check("R11 disable hs_gate", int'(hs_gate), 0);
        check("R11 disable ls_gate", int'(ls_gate), 0);
        check("R11 disable reduced restored", int'(sink_lim_reduced), 1);
        enable = 1'b1;
        act = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (hs_gate || ls_gate || cyc_start) act++;
        end
        check("R11 hold restarts after enable", act, 0);

        // R7: forced start
        force_start = 1'b1;
        wait_start(seen);
        check("R7 forced start begins switching", seen, 1);
        run_period(-1, -1, -1, -1);
        check("R7 hs rise after forced start", int'(hs_s[1]), 1);
        check("R3 clamp fall after forced start", int'(hs_s[95]), 0);

        // R11: reset while the low side is on
        check("R4 ls on at position 0", int'(ls_gate), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset clears ls_gate", int'(ls_gate), 0);
        check("R11 reset clears hs_gate", int'(hs_gate), 0);
        finish_run();
    end

endmodule